// File: doc/BRIEF.md
# MDIO Management Register Bridge

This block gives a host one 32-bit register for reaching the management registers of an Ethernet PHY. Writing that register starts a management frame on the MDC/MDIO pins. The frame is a clause-22 frame: 32 preamble ones, start bits, an opcode, the PHY address, the register address, a turnaround and 16 data bits. Bit 31 of the written word selects the operation. A one asks for a write and a zero asks for a read.

The host polls the same register to learn when the frame has finished. The flag works in opposite directions for the two operations. A read sets bit 31 once the returned data sits in bits 15:0. A write clears bit 31 once the frame has gone out. The PHY address is a build-time constant with a default of 1. MDC comes from a divider of the system clock, and the divider ratio is a parameter with a default of 64.

Top module: `mdio_reg_bridge`

## Requirements
- R1: While reset is asserted and right after it, `host_rdata` reads 0, `mdc` is low and `mdio_oe` is low.
- R2: A host write that is accepted loads bit 31 (operation flag), bits 20:16 (register address) and bits 15:0 (data) at once. Bits 30:21 always read as zero.
- R3: A write request (bit 31 = 1) sends 64 bits, most significant bit first within each field. The bits are: 32 ones, `01`, opcode `01`, the 5-bit PHY address, the 5-bit register address, turnaround `10` and the 16 data bits. `mdio_oe` stays high for the whole frame.
- R4: A read request (bit 31 = 0) sends 32 ones, `01`, opcode `10`, the PHY address and the register address, with `mdio_oe` high for these first 46 bits. It then releases the line (`mdio_oe` low) for the turnaround and the 16 data bits. Data is sampled on rising MDC, most significant bit first.
- R5: When a read frame ends, bit 31 becomes 1 and bits 15:0 hold the sampled data. Bits 20:16 keep the register address.
- R6: When a write frame ends, bit 31 becomes 0 and the other fields are unchanged. Until then bit 31 stays 1.
- R7: A host write that arrives while a frame is in progress has no effect: the register does not change and no extra frame is sent.
- R8: While a frame runs, MDC has a period of `MDC_DIV` system clocks. `mdio_o` changes only on the clock edge where MDC falls. MDC is low whenever no frame is running.
- R9: The PHY address field of every frame equals `PHY_ADDR` (default 00001).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the access register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Current access register contents |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
The assertions check several rules on every cycle:
- MDC stays low when idle, and `mdio_o` moves only when MDC falls.
- Writes are ignored while a frame is busy.
- A write frame keeps the drive enable high throughout, and a read frame releases the line from bit 46 on.
- The flag moves in the right direction at each completion.
- The padding bits of the register stay zero.

Only the bench scenarios can show the rest. A behavioural PHY decodes each frame bit by bit, and a scoreboard compares it with the expected frame. The bench also checks that read data returned by the PHY lands in the register, that the MDC period has the right length, and that an ignored write produces no second frame.

// File: rtl/mdio_bridge_pkg.sv
`timescale 1ns/1ps
package mdio_bridge_pkg;

    localparam int FRAME_LEN    = 64;
    localparam int IDX_W        = $clog2(FRAME_LEN);
    localparam int RD_DRIVE_LEN = 46;   // bits driven by the bridge on a read
    localparam int DATA_FIRST   = 48;   // index of the first data bit
    localparam int DATA_W       = 16;
    localparam int ADDR_W       = 5;

    typedef struct packed {
        logic               flag;
        logic [ADDR_W-1:0]  regad;
        logic [DATA_W-1:0]  data;
    } host_reg_t;

    typedef struct packed {
        host_reg_t r;
        logic      op_wr;
    } bridge_st_t;

    typedef struct packed {
        logic                   busy;
        logic                   wr;
        logic                   oe;
        logic [IDX_W-1:0]       idx;
        logic [FRAME_LEN-1:0]   shift;
        logic [DATA_W-1:0]      rx;
    } eng_st_t;

    // Serial image of one management frame, first bit at the top.
    function automatic logic [FRAME_LEN-1:0] frame_word(
        input logic              wr,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] regad,
        input logic [DATA_W-1:0] data
    );
        logic [1:0]        opc;
        logic [1:0]        ta;
        logic [DATA_W-1:0] pay;
        opc = wr ? 2'b01 : 2'b10;
        ta  = wr ? 2'b10 : 2'b11;
        pay = wr ? data : {DATA_W{1'b1}};
        return {{32{1'b1}}, 2'b01, opc, phy, regad, ta, pay};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tk,
    output logic end_tk
);
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rise_tk = 1'b0;
        end_tk  = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else begin
            if (st_q.cnt == CW'(HALF - 1)) begin
                rise_tk  = 1'b1;
                st_d.mdc = 1'b1;
            end
            if (st_q.cnt == CW'(DIV - 1)) begin
                end_tk   = 1'b1;
                st_d.mdc = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mdc = st_q.mdc;

endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng
    import mdio_bridge_pkg::*;
#(
    parameter int PHY_ADDR = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_wr,
    input  logic [ADDR_W-1:0]  start_regad,
    input  logic [DATA_W-1:0]  start_data,
    input  logic               rise_tk,
    input  logic               end_tk,
    input  logic               mdio_i,
    output logic               busy,
    output logic               done,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic [DATA_W-1:0]  rd_data,
    output logic [IDX_W-1:0]   bit_idx
);
    localparam logic [ADDR_W-1:0] PHY_FIELD = ADDR_W'(PHY_ADDR);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0]  REL_IDX   = IDX_W'(RD_DRIVE_LEN - 1);
    localparam logic [IDX_W-1:0]  DAT_IDX   = IDX_W'(DATA_FIRST);

    eng_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.wr    = start_wr;
                st_d.oe    = 1'b1;
                st_d.idx   = '0;
                st_d.shift = frame_word(start_wr, PHY_FIELD, start_regad, start_data);
            end
        end else begin
            if (rise_tk && !st_q.wr && (st_q.idx >= DAT_IDX)) begin
                st_d.rx = {st_q.rx[DATA_W-2:0], mdio_i};
            end
            if (end_tk) begin
                if (st_q.idx == LAST_IDX) begin
                    done       = 1'b1;
                    st_d.busy  = 1'b0;
                    st_d.oe    = 1'b0;
                    st_d.idx   = '0;
                    st_d.shift = '1;
                end else begin
                    st_d.idx   = st_q.idx + 1'b1;
                    st_d.shift = {st_q.shift[FRAME_LEN-2:0], 1'b1};
                    if (!st_q.wr && (st_q.idx == REL_IDX)) begin
                        st_d.oe = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.shift <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign mdio_o  = st_q.shift[FRAME_LEN-1];
    assign mdio_oe = st_q.oe;
    assign rd_data = st_q.rx;
    assign bit_idx = st_q.idx;

endmodule

// File: rtl/mdio_reg_bridge.sv
`timescale 1ns/1ps
module mdio_reg_bridge
    import mdio_bridge_pkg::*;
#(
    parameter int MDC_DIV  = 64,
    parameter int PHY_ADDR = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int PAD_W = 31 - ADDR_W - DATA_W;

    bridge_st_t st_d, st_q;

    logic              eng_start;
    logic              eng_busy;
    logic              eng_done;
    logic [DATA_W-1:0] eng_rd;
    logic [IDX_W-1:0]  eng_bit;
    logic              rise_tk;
    logic              end_tk;
    logic              unused_pad;

    assign unused_pad = ^host_wdata[30:DATA_W+ADDR_W];

    always_comb begin
        st_d      = st_q;
        eng_start = 1'b0;
        if (host_wr && !eng_busy) begin
            eng_start    = 1'b1;
            st_d.r.flag  = host_wdata[31];
            st_d.r.regad = host_wdata[DATA_W+ADDR_W-1:DATA_W];
            st_d.r.data  = host_wdata[DATA_W-1:0];
            st_d.op_wr   = host_wdata[31];
        end
        if (eng_done) begin
            if (st_q.op_wr) begin
                st_d.r.flag = 1'b0;
            end else begin
                st_d.r.flag = 1'b1;
                st_d.r.data = eng_rd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = {st_q.r.flag, {PAD_W{1'b0}}, st_q.r.regad, st_q.r.data};

    mdio_mdc_gen #(
        .DIV (MDC_DIV)
    ) u_mdc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (eng_busy),
        .mdc     (mdc),
        .rise_tk (rise_tk),
        .end_tk  (end_tk)
    );

    mdio_frame_eng #(
        .PHY_ADDR (PHY_ADDR)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (eng_start),
        .start_wr    (host_wdata[31]),
        .start_regad (host_wdata[DATA_W+ADDR_W-1:DATA_W]),
        .start_data  (host_wdata[DATA_W-1:0]),
        .rise_tk     (rise_tk),
        .end_tk      (end_tk),
        .mdio_i      (mdio_i),
        .busy        (eng_busy),
        .done        (eng_done),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .rd_data     (eng_rd),
        .bit_idx     (eng_bit)
    );

endmodule

// File: rtl/mdio_bridge_chk.sv
`timescale 1ns/1ps
module mdio_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic [31:0] host_rdata,
    input logic        busy,
    input logic        done,
    input logic        op_wr,
    input logic [5:0]  bit_idx,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R8

    AST_DATA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc)); // R8

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && host_wr) |=> $stable(host_rdata)); // R7

    AST_WRITE_DRIVES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_wr) |-> mdio_oe); // R3

    AST_READ_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_wr && (bit_idx >= 6'd46)) |-> !mdio_oe); // R4

    AST_WRITE_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_wr) |=> !host_rdata[31]); // R6

    AST_READ_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_wr) |=> host_rdata[31]); // R5

    AST_PAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[30:21] == 10'd0); // R2

endmodule

bind mdio_reg_bridge mdio_bridge_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rdata (host_rdata),
    .busy       (eng_busy),
    .done       (eng_done),
    .op_wr      (st_q.op_wr),
    .bit_idx    (eng_bit),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
);

// File: tb/mdio_reg_bridge_tb.sv
`timescale 1ns/1ps
module mdio_reg_bridge_tb;

    localparam int DIV       = 16;
    localparam int FRAME_CYC = 64 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        sl_drv = 1'b1;

    always #4 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : sl_drv;

    mdio_reg_bridge #(.MDC_DIV(DIV), .PHY_ADDR(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    int tests = 0;
    int fails = 0;
    int frames_seen = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [63:0] line;
        logic [63:0] oe;
        logic        wr;
    } exp_t;
    exp_t exp_q[$];

    function automatic logic [15:0] phy_val(input logic [4:0] ra);
        return {3'b101, ra, 3'b011, ~ra};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Behavioural PHY and scoreboard monitor
    int          sl_idx = 0;
    logic [63:0] sl_line = '0;
    logic [63:0] sl_oe = '0;
    logic        sl_rd = 1'b0;
    logic [4:0]  sl_ra = '0;

    always @(posedge mdc) begin
        sl_line = {sl_line[62:0], mdio_i};
        sl_oe   = {sl_oe[62:0], mdio_oe};
        sl_idx++;
        if (sl_idx == 36) sl_rd = (sl_line[1:0] == 2'b10);
        if (sl_idx == 46) sl_ra = sl_line[4:0];
        if (sl_idx == 64) begin
            sl_idx = 0;
            frames_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected frame", sl_line, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(sl_line == e.line, e.wr ? "R3" : "R4", "frame bits", sl_line, e.line);
                chk(sl_oe == e.oe, e.wr ? "R3" : "R4", "drive enable", sl_oe, e.oe);
                chk(sl_line[27:23] == 5'd1, "R9", "phy address",
                    64'(sl_line[27:23]), 64'd1);
            end
        end
    end

    always @(negedge mdc) begin
        logic [15:0] v;
        v = phy_val(sl_ra);
        if (sl_rd && sl_idx == 47) sl_drv = 1'b0;
        else if (sl_rd && sl_idx >= 48) sl_drv = v[63 - sl_idx];
        else sl_drv = 1'b1;
    end

    // Driver
    task automatic host_write(input logic [31:0] v);
        @(negedge clk);
        host_wr    = 1'b1;
        host_wdata = v;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic send(input logic [31:0] v);
        exp_t e;
        logic [4:0] ra;
        ra = v[20:16];
        e.wr = v[31];
        if (v[31]) begin
            e.line = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'b00001, ra, 2'b10, v[15:0]};
            e.oe   = '1;
        end else begin
            e.line = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'b00001, ra, 2'b10, phy_val(ra)};
            e.oe   = {{46{1'b1}}, {18{1'b0}}};
        end
        exp_q.push_back(e);
        host_write(v);
    endtask

    task automatic wait_frame();
        repeat (FRAME_CYC + 8) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        longint t1, t2;
        repeat (3) @(negedge clk);
        chk(host_rdata == 32'd0 && !mdc && !mdio_oe, "R1", "in reset",
            64'(host_rdata), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(host_rdata == 32'd0 && !mdc && !mdio_oe, "R1", "after reset",
            64'(host_rdata), 64'd0);

        // Write with padding bits set in the request
        send(32'hFFE5_BEEF);
        chk(host_rdata == 32'h8005_BEEF, "R2", "fields loaded", 64'(host_rdata), 64'h8005_BEEF);
        @(posedge mdc); t1 = $time;
        @(posedge mdc); t2 = $time;
        chk((t2 - t1) == 64'(8 * DIV), "R8", "mdc period", 64'(t2 - t1), 64'(8 * DIV));
        host_write(32'h0003_1111);
        @(negedge clk);
        chk(host_rdata == 32'h8005_BEEF, "R7", "write while busy", 64'(host_rdata), 64'h8005_BEEF);
        chk(host_rdata[31], "R6", "flag held during write", 64'(host_rdata[31]), 64'd1);
        wait_frame();
        chk(host_rdata == 32'h0005_BEEF, "R6", "write done", 64'(host_rdata), 64'h0005_BEEF);
        chk(!mdc && !mdio_oe, "R8", "idle lines", 64'({mdc, mdio_oe}), 64'd0);

        // Read from the highest register
        send(32'h001F_ABCD);
        chk(host_rdata == 32'h001F_ABCD, "R2", "read request loaded", 64'(host_rdata), 64'h001F_ABCD);
        wait_frame();
        chk(host_rdata == {1'b1, 10'd0, 5'h1F, phy_val(5'h1F)}, "R5", "read reg 31",
            64'(host_rdata), 64'({1'b1, 10'd0, 5'h1F, phy_val(5'h1F)}));

        // Read register 0
        send(32'h0000_0000);
        wait_frame();
        chk(host_rdata == {1'b1, 10'd0, 5'h00, phy_val(5'h00)}, "R5", "read reg 0",
            64'(host_rdata), 64'({1'b1, 10'd0, 5'h00, phy_val(5'h00)}));

        // Write register 10 with a sparse pattern
        send(32'h800A_0001);
        wait_frame();
        chk(host_rdata == 32'h000A_0001, "R6", "write reg 10", 64'(host_rdata), 64'h000A_0001);

        // Read with an ignored write in the middle of the frame
        send(32'h000C_0000);
        repeat (300) @(negedge clk);
        host_write(32'h8007_5555);
        @(negedge clk);
        chk(host_rdata == 32'h000C_0000, "R7", "write during read", 64'(host_rdata), 64'h000C_0000);
        wait_frame();
        chk(host_rdata == {1'b1, 10'd0, 5'h0C, phy_val(5'h0C)}, "R5", "read reg 12",
            64'(host_rdata), 64'({1'b1, 10'd0, 5'h0C, phy_val(5'h0C)}));

        wait_frame();
        chk(exp_q.size() == 0, "R7", "frames pending", 64'(exp_q.size()), 64'd0);
        chk(frames_seen == 5, "R7", "frame count", 64'(frames_seen), 64'd5);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule